// File: doc/BRIEF.md
# Bit-Serial CRC-5 Encoder and Verifier

This block computes a 5-bit cyclic redundancy code one bit per clock. The divisor is X^5+X^4+X^2+1 (binary 110101). The block has two modes, and both use the same five-stage shift register with XOR feedback.

In generate mode, a message of any length is shifted in most significant bit first. Each accepted bit is echoed on the serial output. After the last message bit, the block emits the 5-bit remainder of the message times X^5 divided by the divisor. This frame check sequence follows the message directly on the serial output.

In check mode, a complete received frame is shifted in (the message followed by its check bits). One cycle after the last bit is accepted, the error flag shows whether the frame left a nonzero remainder.

All arithmetic is modulo 2, so addition is XOR with no carries. A frame built by this block divides exactly by the divisor. Corruption is therefore missed only when the error pattern is itself a multiple of the divisor.

Top module: `crc5_serial_unit`

## Requirements
- R1: The divisor is fixed at 110101. In generate mode the five check bits equal the remainder of (message times X^5) divided by that divisor, and they are emitted most significant bit first.
- R2: In generate mode, every message bit accepted (bit_vld high) appears on dout with dout_vld high in the cycle after its acceptance.
- R3: The five check bits appear on dout with dout_vld high on five consecutive cycles. These cycles begin directly after the echo of the final message bit, which is the bit accepted with msg_end high.
- R4: During the five check-bit cycles, bit_vld, bit_in and msg_end are ignored. The emitted check bits do not change, and a message started after them gets the same check bits as it would from a clean start.
- R5: In check mode, err is updated one cycle after the bit accepted with msg_end high. It becomes 1 when the frame remainder is nonzero and 0 when it is zero. At all other times err keeps its value, including during generate-mode traffic.
- R6: In check mode, dout_vld stays low.
- R7: The register returns to all zeros after every message and every frame, so consecutive messages and frames do not affect each other.
- R8: While rst_n is low, and after it is released, dout_vld is 0, err is 0 and the register is all zeros.
- R9: The message 1010001101 produces the check bits 01110.
- R10: A frame with any single inverted bit sets err. A valid frame XORed with the divisor pattern 110101 at any bit offset leaves err at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_mode | input | 1 | 0 = generate mode, 1 = check mode; held stable through a message or frame |
| bit_vld | input | 1 | Strobe: bit_in is accepted on this edge |
| bit_in | input | 1 | Serial data input, most significant bit first |
| msg_end | input | 1 | Marks the accepted bit as the last of the message or frame |
| dout | output | 1 | Serial output: echoed message bits, then the check bits |
| dout_vld | output | 1 | dout carries a valid bit |
| err | output | 1 | Nonzero remainder found on the last checked frame |

## Verification
The stimulus combines directed and random patterns, each aimed at a different failure.

- The known message 1010001101 ties the remainder to a fixed value, which exposes a wrong tap position or a wrong shift direction.
- A one-bit message tests the case where the first accepted bit is also the last.
- Random messages of 1 to 40 bits, some with garbage strobes during the check-bit cycles, separate correct remainder arithmetic from state that leaks from one message into the next.
- In check mode, three kinds of frame are used:
  - untouched frames, which must give a zero remainder;
  - frames with one inverted bit, which must be detected;
  - frames XORed with a shifted copy of the divisor, which must pass.

  Together these show that the flag comes from the division itself and not from a simpler parity-like test.

// File: rtl/crc5_serial_pkg.sv
package crc5_serial_pkg;
   localparam int unsigned CRC_W_DEF = 5;
   localparam logic [5:0] CRC_POLY_DEF = 6'b110101;

   typedef enum logic {
      PH_RUN   = 1'b0,
      PH_FLUSH = 1'b1
   } crc_phase_e;
endpackage

// File: rtl/crc5_lfsr_step.sv
module crc5_lfsr_step #(
   parameter int unsigned W = 5,
   parameter logic [W:0] POLY = 6'b110101
) (
   input  logic [W-1:0] state_q,
   input  logic         din,
   output logic [W-1:0] state_d
);
   logic fb;

   assign fb = state_q[W-1] ^ din;

   generate
      if (POLY[W] != 1'b1 || POLY[0] != 1'b1) begin : g_bad_poly
         $error("divisor needs its top and constant terms set");
      end
      for (genvar i = 0; i < W; i++) begin : g_stage
         if (i == 0) begin : g_first
            if (POLY[0]) begin : g_tap
               assign state_d[0] = fb;
            end else begin : g_notap
               assign state_d[0] = 1'b0;
            end
         end else begin : g_rest
            if (POLY[i]) begin : g_tap
               assign state_d[i] = state_q[i-1] ^ fb;
            end else begin : g_notap
               assign state_d[i] = state_q[i-1];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/crc5_seq_ctrl.sv
module crc5_seq_ctrl
   import crc5_serial_pkg::*;
#(
   parameter int unsigned W = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_flush,
   output logic in_flush
);
   localparam int unsigned CW = $clog2(W + 1);
   localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

   crc_phase_e    phase_q;
   logic [CW-1:0] cnt_q;

   generate
      if (W < 2) begin : g_bad_w
         $error("register width must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_RUN;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_RUN: begin
               if (go_flush) begin
                  phase_q <= PH_FLUSH;
                  cnt_q   <= '0;
               end
            end
            PH_FLUSH: begin
               if (cnt_q == LAST_CNT) begin
                  phase_q <= PH_RUN;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: phase_q <= PH_RUN;
         endcase
      end
   end

   assign in_flush = (phase_q == PH_FLUSH);

   AST_FLUSH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_CNT); // R3
   AST_FLUSH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (go_flush && !in_flush) |=> (in_flush && cnt_q == '0)); // R3
endmodule

// File: rtl/crc5_serial_unit.sv
module crc5_serial_unit
   import crc5_serial_pkg::*;
#(
   parameter int unsigned W = CRC_W_DEF,
   parameter logic [W:0] POLY = CRC_POLY_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chk_mode,
   input  logic bit_vld,
   input  logic bit_in,
   input  logic msg_end,
   output logic dout,
   output logic dout_vld,
   output logic err
);
   logic [W-1:0] crc_q;
   logic [W-1:0] crc_step;
   logic         in_flush;
   logic         accept;
   logic         go_flush;
   logic         step_din;

   assign accept   = bit_vld && !in_flush;
   assign go_flush = accept && msg_end && !chk_mode;
   // while flushing, feeding the top bit back cancels the feedback: a plain shift with zero fill
   assign step_din = in_flush ? crc_q[W-1] : bit_in;

   crc5_lfsr_step #(.W(W), .POLY(POLY)) u_step (
      .state_q (crc_q),
      .din     (step_din),
      .state_d (crc_step)
   );

   crc5_seq_ctrl #(.W(W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_flush (go_flush),
      .in_flush (in_flush)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q    <= '0;
         dout     <= 1'b0;
         dout_vld <= 1'b0;
         err      <= 1'b0;
      end else begin
         dout_vld <= 1'b0;
         if (in_flush) begin
            crc_q    <= crc_step;
            dout     <= crc_q[W-1];
            dout_vld <= 1'b1;
         end else if (accept) begin
            dout     <= bit_in;
            dout_vld <= !chk_mode;
            if (msg_end && chk_mode) begin
               err   <= |crc_step;
               crc_q <= '0;
            end else begin
               crc_q <= crc_step;
            end
         end
      end
   end

   AST_ECHO_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !chk_mode) |=> (dout_vld && dout == $past(bit_in))); // R2
   AST_FLUSH_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
      in_flush |=> dout_vld); // R3
   AST_CHECK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && chk_mode) |=> !dout_vld); // R6
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(accept && chk_mode && msg_end) |=> $stable(err)); // R5
   AST_REG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_flush) |-> (crc_q == '0)); // R7
endmodule

// File: tb/crc5_serial_unit_bench.sv
module crc5_serial_unit_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chk_mode = 1'b0;
   logic bit_vld = 1'b0;
   logic bit_in = 1'b0;
   logic msg_end = 1'b0;
   logic dout, dout_vld, err;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   crc5_serial_unit u_crc5_serial_unit (
      .clk(clk), .rst_n(rst_n), .chk_mode(chk_mode), .bit_vld(bit_vld),
      .bit_in(bit_in), .msg_end(msg_end), .dout(dout), .dout_vld(dout_vld), .err(err)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // long division of (v * X^5) by 110101, v taken as n bits
   function automatic logic [4:0] ref_rem(input logic [63:0] v, input int n);
      logic [5:0] r = '0;
      for (int i = n + 4; i >= 0; i--) begin
         r = {r[4:0], (i >= 5) ? v[i-5] : 1'b0};
         if (r[5]) r = r ^ 6'b110101;
      end
      return r[4:0];
   endfunction

   // generate mode: echo (R2), check bits (R1/R3), noise while flushing (R4)
   task automatic gen_msg(input logic [63:0] m, input int n, input logic [4:0] exp, input bit noise);
      chk_mode = 1'b0;
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk);
         if (i < n - 1) chk("R2 echo", {dout_vld, dout}, {1'b1, m[i+1]});
         bit_vld = 1'b1; bit_in = m[i]; msg_end = (i == 0);
      end
      @(negedge clk);
      chk("R2 echo last", {dout_vld, dout}, {1'b1, m[0]});
      bit_vld = noise; bit_in = 1'($urandom); msg_end = noise;
      for (int j = 4; j >= 0; j--) begin
         @(negedge clk);
         chk(noise ? "R4 R1 R3 fcs bit under noise" : "R1 R3 fcs bit",
             {dout_vld, dout}, {1'b1, exp[j]});
         if (j > 0) begin
            bit_vld = noise; bit_in = 1'($urandom); msg_end = 1'($urandom);
         end else begin
            bit_vld = 1'b0; msg_end = 1'b0;
         end
      end
   endtask

   task automatic chk_frame(input logic [63:0] f, input int n, input logic exp_err, input string req);
      chk_mode = 1'b1;
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk);
         if (i < n - 1) chk("R6 quiet in check mode", {63'd0, dout_vld}, 64'd0);
         bit_vld = 1'b1; bit_in = f[i]; msg_end = (i == 0);
      end
      @(negedge clk);
      chk(req, {63'd0, err}, {63'd0, exp_err});
      bit_vld = 1'b0; msg_end = 1'b0;
   endtask

   initial begin
      logic [63:0] m, f;
      logic [4:0]  fcs;
      int          n, kind;
      void'($urandom(32'd1234));
      #5;
      chk("R8 reset dout_vld", {63'd0, dout_vld}, 64'd0);
      chk("R8 reset err", {63'd0, err}, 64'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 after reset", {62'd0, dout_vld, err}, 64'd0);

      // R9 known message, clean and then with noise during flush
      gen_msg(64'b1010001101, 10, 5'b01110, 1'b0);
      gen_msg(64'b1010001101, 10, 5'b01110, 1'b1);
      // R7 back-to-back single-bit messages
      gen_msg(64'd1, 1, ref_rem(64'd1, 1), 1'b0);
      gen_msg(64'd1, 1, 5'b10101, 1'b1);

      // R5 / R10 directed frames
      f = (64'b1010001101 << 5) | 64'b01110;
      chk_frame(f, 15, 1'b0, "R5 clean frame");
      chk_frame(f ^ 64'd1, 15, 1'b1, "R10 flipped lsb");
      chk_frame(f ^ (64'd1 << 14), 15, 1'b1, "R10 flipped msb");
      chk_frame(f ^ (64'h35 << 4), 15, 1'b0, "R10 divisor pattern undetected");
      chk_frame(f ^ 64'd4, 15, 1'b1, "R10 flipped bit 2");
      gen_msg(64'h3, 2, ref_rem(64'h3, 2), 1'b0);
      chk("R5 err held over generate traffic", {63'd0, err}, 64'd1);

      for (int it = 0; it < 40; it++) begin
         n = 1 + int'($urandom % 40);
         m = {$urandom, $urandom} & ((64'd1 << n) - 1);
         fcs = ref_rem(m, n);
         gen_msg(m, n, fcs, 1'($urandom));
         f = (m << 5) | {59'd0, fcs};
         kind = int'($urandom % 3);
         if (kind == 1) f = f ^ (64'd1 << ($urandom % (n + 5)));
         if (kind == 2) f = f ^ (64'h35 << ($urandom % n));
         chk_frame(f, n + 5, (ref_rem(f, n + 5) != 5'd0),
                   kind == 2 ? "R10 random divisor pattern" : "R5 random frame");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule